// File: doc/BRIEF.md
# Serial Tuning Control Word Register

This block takes a 24-bit control word from a host controller one bit at a time and holds it for the rest of a frequency synthesizer. The host raises an enable line and presents one data bit per rising edge of the serial clock. When enable drops, the collected word is copied into a parallel holding register. The held word stays fixed until the next copy.

The holding register is split into fields. These are a 14-bit loop divide code, a premix modulus select, a reference frequency select and a mute timer trigger. A two-bit pin mode field chooses what three status pins show. In normal mode they show three status bits from the word. In any of the three test modes they pass through externally supplied observation signals, and a one-hot test select tells neighbouring logic which test mode is active.

A one-cycle strobe marks every copy into the holding register, including a copy of the same data. This lets the timer and other consumers react to each new word.

Top module: `serial_ctl_reg`

## Requirements
- R1: After a synchronous reset every held field, the status pins, the test select and the strobe are all zero.
- R2: The first 14 bits of a frame (frame bits 1 to 14, in arrival order) form `div_code`, with the first bit received as its most significant bit.
- R3: Frame bits 15 and 16 form `premix_sel` as {bit15, bit16}. Frame bits 17 and 18 form `ref_sel` as {bit17, bit18}.
- R4: `timer_trig` equals frame bit 19 of the held word.
- R5: A bit is shifted in only at a rising clock edge where `ser_en` is high. The held outputs do not change while a frame is being shifted or while the line is idle. They change only when the word is committed.
- R6: The word is committed at the first rising edge at which `ser_en` is sampled low after having been sampled high. In the cycle that follows, `latch_stb` is high for exactly one cycle and the new fields are visible.
- R7: Committing a word identical to the held one still produces the one-cycle `latch_stb`.
- R8: If more than 24 bits are clocked in during one enable window, only the last 24 bits received are committed.
- R9: The pin mode is {bit20, bit21}. When it is 00 (normal), `stat_pins` = {bit22, bit23, bit24} and `test_sel` is 000.
- R10: Pin mode codes 01, 10 and 11 select test modes 1, 2 and 3. In a test mode, `test_sel` is one-hot with bit (code-1) set, and `stat_pins` follows `test_obs` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; data sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_en | input | 1 | Enable: shift while high, commit on its fall |
| ser_data | input | 1 | Serial data bit |
| test_obs | input | 3 | Observation signals shown on the pins in test modes |
| div_code | output | 14 | Held loop divide code |
| premix_sel | output | 2 | Held premix modulus select |
| ref_sel | output | 2 | Held reference frequency select |
| timer_trig | output | 1 | Held mute timer trigger bit |
| test_sel | output | 3 | One-hot active test mode, zero in normal mode |
| stat_pins | output | 3 | Status pins: held status bits or test observation |
| latch_stb | output | 1 | One-cycle pulse after each commit |

## Verification
The bench builds the block with the package defaults: a 24-bit frame with a 14-bit divide code and three status pins. These defaults exercise every pin mode code and the full range of the divide code, from all ones down to a single set bit. They also cover frames longer than the register, where the leading bits must be pushed out, and back-to-back commits of identical words. Observation inputs change during test mode to show the pins follow them, and stop mattering when the mode returns to normal.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int DIV_W   = 14;
    localparam int PM_W    = 2;
    localparam int RS_W    = 2;
    localparam int MODE_W  = 2;
    localparam int PIN_W   = 3;
    localparam int FRAME_W = DIV_W + PM_W + RS_W + 1 + MODE_W + PIN_W;
    localparam int N_TEST  = (1 << MODE_W) - 1;

    typedef enum logic [MODE_W-1:0] {
        PMODE_NORMAL = 2'b00,
        PMODE_TEST1  = 2'b01,
        PMODE_TEST2  = 2'b10,
        PMODE_TEST3  = 2'b11
    } pin_mode_e;

    // Field order follows arrival order: first received bit lands at MSB.
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PM_W-1:0]  premix;
        logic [RS_W-1:0]  refsel;
        logic             timer;
        pin_mode_e        mode;
        logic [PIN_W-1:0] status;
    } ctl_word_t;

    function automatic ctl_word_t unpack_word(input logic [FRAME_W-1:0] raw);
        ctl_word_t w;
        w = ctl_word_t'(raw);
        return w;
    endfunction

endpackage

// File: rtl/ctl_shift.sv
module ctl_shift
    import ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               din,
    output logic [FRAME_W-1:0] shreg,
    output logic               commit
);

    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            en_q  <= 1'b0;
        end else begin
            en_q <= en;
            if (en) begin
                shreg <= {shreg[FRAME_W-2:0], din};
            end
        end
    end

    assign commit = en_q && !en;

    AST_SHIFT_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!$past(en) && !$past(rst)) |-> $stable(shreg)) else $error("shift reg moved while idle"); // R5

endmodule

// File: rtl/ctl_hold.sv
module ctl_hold
    import ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame_in,
    output ctl_word_t          held,
    output logic               stb
);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            stb  <= 1'b0;
        end else begin
            stb <= commit;
            if (commit) begin
                held <= unpack_word(frame_in);
            end
        end
    end

    AST_HOLD_LOADS: assert property (@(posedge clk) disable iff (rst)
        stb |-> (held == ctl_word_t'($past(frame_in)))) else $error("held word mismatch"); // R6

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!stb && !$past(rst)) |-> $stable(held)) else $error("held word changed without strobe"); // R5

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
        stb |=> !stb) else $error("strobe longer than one cycle"); // R6

endmodule

// File: rtl/ctl_pins.sv
module ctl_pins
    import ctl_pkg::*;
(
    input  pin_mode_e         mode,
    input  logic [PIN_W-1:0]  status,
    input  logic [PIN_W-1:0]  obs,
    output logic [PIN_W-1:0]  pins,
    output logic [N_TEST-1:0] tsel
);

    logic normal;
    assign normal = (mode == PMODE_NORMAL);

    for (genvar i = 0; i < PIN_W; i++) begin : g_pin
        assign pins[i] = normal ? status[i] : obs[i];
    end

    for (genvar j = 0; j < N_TEST; j++) begin : g_tsel
        assign tsel[j] = (mode == pin_mode_e'(j + 1));
    end

    always_comb begin
        AST_TEST_ONEHOT: assert ($onehot0(tsel)) else $error("test select not one-hot"); // R10
    end

endmodule

// File: rtl/serial_ctl_reg.sv
module serial_ctl_reg
    import ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_en,
    input  logic              ser_data,
    input  logic [PIN_W-1:0]  test_obs,
    output logic [DIV_W-1:0]  div_code,
    output logic [PM_W-1:0]   premix_sel,
    output logic [RS_W-1:0]   ref_sel,
    output logic              timer_trig,
    output logic [N_TEST-1:0] test_sel,
    output logic [PIN_W-1:0]  stat_pins,
    output logic              latch_stb
);

    logic [FRAME_W-1:0] shreg;
    logic               commit;
    ctl_word_t          held;

    ctl_shift u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (ser_en),
        .din    (ser_data),
        .shreg  (shreg),
        .commit (commit)
    );

    ctl_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .commit   (commit),
        .frame_in (shreg),
        .held     (held),
        .stb      (latch_stb)
    );

    ctl_pins u_pins (
        .mode   (held.mode),
        .status (held.status),
        .obs    (test_obs),
        .pins   (stat_pins),
        .tsel   (test_sel)
    );

    assign div_code   = held.div;
    assign premix_sel = held.premix;
    assign ref_sel    = held.refsel;
    assign timer_trig = held.timer;

    AST_COMMIT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!ser_en && $past(ser_en) && !$past(rst)) |=> latch_stb) else $error("no strobe after enable fall"); // R6

    AST_NO_STRAY_STB: assert property (@(posedge clk) disable iff (rst)
        ser_en |=> !latch_stb) else $error("strobe while shifting"); // R6

endmodule

// File: tb/test_serial_ctl_reg.sv
module test_serial_ctl_reg;

    localparam int CLK_P = 10;
    localparam int NV    = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        ser_en;
    logic        ser_data;
    logic [2:0]  test_obs;
    logic [13:0] div_code;
    logic [1:0]  premix_sel;
    logic [1:0]  ref_sel;
    logic        timer_trig;
    logic [2:0]  test_sel;
    logic [2:0]  stat_pins;
    logic        latch_stb;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    serial_ctl_reg i_serial_ctl_reg (
        .clk        (clk),
        .rst        (rst),
        .ser_en     (ser_en),
        .ser_data   (ser_data),
        .test_obs   (test_obs),
        .div_code   (div_code),
        .premix_sel (premix_sel),
        .ref_sel    (ref_sel),
        .timer_trig (timer_trig),
        .test_sel   (test_sel),
        .stat_pins  (stat_pins),
        .latch_stb  (latch_stb)
    );

    // entry: {div[13:0], premix[1:0], ref[1:0], timer, mode[1:0], status[2:0], obs[2:0]}
    localparam logic [26:0] VEC [NV] = '{
        {14'h2A5B, 2'b01, 2'b10, 1'b1, 2'b00, 3'b101, 3'b010},
        {14'h3FFF, 2'b11, 2'b11, 1'b0, 2'b00, 3'b011, 3'b000},
        {14'h0001, 2'b00, 2'b01, 1'b1, 2'b01, 3'b110, 3'b101},
        {14'h1234, 2'b10, 2'b00, 1'b0, 2'b10, 3'b111, 3'b011},
        {14'h0F0F, 2'b01, 2'b11, 1'b1, 2'b11, 3'b000, 3'b110},
        {14'h2000, 2'b10, 2'b10, 1'b0, 2'b00, 3'b010, 3'b111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_sel(input logic [1:0] md);
        return (md == 2'b00) ? 3'b000 : (3'b001 << (md - 2'd1));
    endfunction

    function automatic logic [2:0] exp_pins(input logic [1:0] md, input logic [2:0] st,
                                            input logic [2:0] ob);
        return (md == 2'b00) ? st : ob;
    endfunction

    // Send junk bits first, then the 24 frame bits MSB first; enable stays high.
    task automatic shift_in(input logic [23:0] f, input int junk);
        for (int k = 0; k < junk; k++) begin
            @(negedge clk);
            ser_en   = 1'b1;
            ser_data = k[0];
        end
        for (int k = 23; k >= 0; k--) begin
            @(negedge clk);
            ser_en   = 1'b1;
            ser_data = f[k];
        end
        @(negedge clk);
    endtask

    // Called at a negedge with enable high: drop enable, check the commit cycle.
    task automatic commit_and_check(input logic [26:0] v, input string tag);
        logic [1:0] md;
        md     = v[7:6];
        ser_en = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk({"R6 strobe ", tag}, 32'(latch_stb), 32'd1);
        chk({"R2 div ", tag}, 32'(div_code), 32'(v[26:13]));
        chk({"R3 premix/ref ", tag}, 32'({premix_sel, ref_sel}), 32'(v[12:9]));
        chk({"R4 timer ", tag}, 32'(timer_trig), 32'(v[8]));
        chk({"R9 R10 test_sel ", tag}, 32'(test_sel), 32'(exp_sel(md)));
        chk({"R9 R10 pins ", tag}, 32'(stat_pins), 32'(exp_pins(md, v[5:3], v[2:0])));
        @(negedge clk);
        chk({"R6 strobe drop ", tag}, 32'(latch_stb), 32'd0);
    endtask

    initial begin
        #(CLK_P * 20000);
        n_bad++;
        n_cmp++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [26:0] prev;
        rst      = 1'b1;
        ser_en   = 1'b0;
        ser_data = 1'b0;
        test_obs = 3'b000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset fields", 32'({div_code, premix_sel, ref_sel, timer_trig}), 32'd0);
        chk("R1 reset pins", 32'({test_sel, stat_pins, latch_stb}), 32'd0);

        prev = '0;
        for (int i = 0; i < NV; i++) begin
            test_obs = VEC[i][2:0];
            shift_in(VEC[i][26:3], 0);
            // R5: nothing committed yet, previous word still held
            chk("R5 hold during shift", 32'({div_code, premix_sel, ref_sel, timer_trig}),
                32'(prev[26:8]));
            chk("R5 no strobe during shift", 32'(latch_stb), 32'd0);
            commit_and_check(VEC[i], $sformatf("vec%0d", i));
            prev = VEC[i];
        end

        // R7: identical word again still strobes
        shift_in(prev[26:3], 0);
        commit_and_check(prev, "R7 rewrite");

        // R5: idle line with data toggling changes nothing
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            ser_data = ~ser_data;
            chk("R5 idle strobe", 32'(latch_stb), 32'd0);
            chk("R5 idle div", 32'(div_code), 32'(prev[26:13]));
        end

        // R8: over-length frame keeps last 24 bits
        test_obs = VEC[2][2:0];
        shift_in(VEC[2][26:3], 7);
        commit_and_check(VEC[2], "R8 overlength");

        // R10: pins follow observation inputs live in test mode
        @(negedge clk);
        test_obs = 3'b010;
        #1;
        chk("R10 live obs", 32'(stat_pins), 32'd2);
        test_obs = 3'b111;
        #1;
        chk("R10 live obs2", 32'(stat_pins), 32'd7);

        // R9: back in normal mode the observation inputs do not reach the pins
        test_obs = 3'b000;
        shift_in(VEC[0][26:3], 0);
        commit_and_check(VEC[0], "R9 normal again");
        test_obs = 3'b111;
        #1;
        chk("R9 obs ignored", 32'(stat_pins), 32'(VEC[0][5:3]));

        // R1: reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset fields", 32'({div_code, premix_sel, ref_sel, timer_trig}), 32'd0);
        chk("R1 mid reset pins", 32'({test_sel, stat_pins, latch_stb}), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule